// File: doc/BRIEF.md
# Two-Symbol Receive Word Assembler

This block sits on the receive side of a serial link after symbol alignment. It takes one serial bit per strobed cycle and collects ten bits into a coded 10-bit group. A configuration input sets whether the first bit on the wire is coded bit "a" or coded bit "j". Each finished group goes out to an external 8b/10b decoder.

The decoder sends back one decoded symbol at a time. Each symbol carries a byte, a control flag and an error flag, and the error flag covers both disparity errors and invalid code groups. The block pairs consecutive symbols into one 20-bit word and announces the word with a single-cycle valid pulse. A second configuration input sets which half of the word the first symbol of a pair fills.

Top module: `rx_pair_assembler`

## Requirements
- R1: After reset, `enc_valid` and `word_valid` are low and `word_data` is zero. The first valid serial bit after reset is bit one of a symbol, and the first decoded symbol after reset is the first symbol of a pair, even if reset arrived when only half a pair had been received.
- R2: `enc_group` holds coded bit "a" at bit 9 down to coded bit "j" at bit 0. When `cfg_a_first` is 1, the first received serial bit of a symbol lands at bit 9.
- R3: When `cfg_a_first` is 0, the first received serial bit of a symbol lands at bit 0 and the tenth lands at bit 9.
- R4: `enc_valid` is high for exactly one cycle, in the cycle after the clock edge that samples the tenth valid serial bit. Cycles with `ser_valid` low neither shift nor count.
- R5: Each 10-bit half of `word_data` is {error, control, byte}. The upper half uses bit 19 for error, bit 18 for control and bits 17:10 for the byte. The lower half uses bits 9, 8 and 7:0. The byte MSB sits at bit 17 or bit 7.
- R6: When `cfg_low_first` is 0, the first symbol of a pair fills the upper half and the second symbol fills the lower half.
- R7: When `cfg_low_first` is 1, the first symbol of a pair fills the lower half and the second symbol fills the upper half.
- R8: `word_valid` pulses for one cycle, in the cycle after the edge that accepts the second symbol of a pair. `word_data` stays unchanged until the next word completes.
- R9: Each error bit is active high and reflects only its own symbol. An error in one word never shows up in a later word.
- R10: Serial assembly and word pairing are independent. A tenth serial bit and a second decoded symbol arriving in the same cycle both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_a_first | input | 1 | 1: first serial bit is coded bit a; 0: first is bit j |
| cfg_low_first | input | 1 | 1: first symbol of a pair fills the lower half |
| ser_valid | input | 1 | Serial bit strobe |
| ser_bit | input | 1 | Serial data bit |
| enc_valid | output | 1 | Coded group ready for the decoder |
| enc_group | output | 10 | Coded group, bit 9 = a … bit 0 = j |
| dec_valid | input | 1 | Decoded symbol strobe |
| dec_err | input | 1 | Disparity or invalid-code error for this symbol |
| dec_ctrl | input | 1 | Control-character flag |
| dec_byte | input | 8 | Decoded byte |
| word_valid | output | 1 | One-cycle pulse for a completed word |
| word_data | output | 20 | Two-symbol word |

## Verification
Two things can happen in the same cycle. The tenth serial bit of one symbol can finish a coded group while the decoder returns the second symbol of a pair and finishes a word. The bench provokes this by driving `dec_valid` in the same cycle as a tenth serial bit. In the cycle that follows, it checks both the coded group and its pulse, and the assembled word and its pulse, each against the values it expects on its own.

// File: rtl/rx_pair_assembler.sv
module rx_pair_assembler #(
  parameter int SYM_W  = 10,
  parameter int BYTE_W = 8,
  localparam int LANE_W = BYTE_W + 2,
  localparam int CW     = $clog2(SYM_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_a_first,
  input  logic                  cfg_low_first,
  input  logic                  ser_valid,
  input  logic                  ser_bit,
  output logic                  enc_valid,
  output logic [SYM_W-1:0]      enc_group,
  input  logic                  dec_valid,
  input  logic                  dec_err,
  input  logic                  dec_ctrl,
  input  logic [BYTE_W-1:0]     dec_byte,
  output logic                  word_valid,
  output logic [2*LANE_W-1:0]   word_data
);

  logic [SYM_W-1:0]  sh;
  logic [SYM_W-1:0]  sh_nxt;
  logic [CW-1:0]     cnt;
  logic [LANE_W-1:0] hold;
  logic [LANE_W-1:0] lane_in;
  logic              have_first;

  assign sh_nxt  = cfg_a_first ? {sh[SYM_W-2:0], ser_bit} : {ser_bit, sh[SYM_W-1:1]};
  assign lane_in = {dec_err, dec_ctrl, dec_byte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= '0;
      cnt       <= '0;
      enc_valid <= 1'b0;
      enc_group <= '0;
    end else begin
      enc_valid <= 1'b0;
      if (ser_valid) begin
        sh <= sh_nxt;
        if (cnt == CW'(SYM_W - 1)) begin
          cnt       <= '0;
          enc_group <= sh_nxt;
          enc_valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold       <= '0;
      have_first <= 1'b0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (dec_valid) begin
        if (!have_first) begin
          hold       <= lane_in;
          have_first <= 1'b1;
        end else begin
          word_data  <= cfg_low_first ? {lane_in, hold} : {hold, lane_in};
          word_valid <= 1'b1;
          have_first <= 1'b0;
          hold       <= '0;
        end
      end
    end
  end

  a_r4_enc_single: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |=> !enc_valid);
  a_r4_enc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |-> $past(ser_valid));
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(SYM_W));
  a_r8_word_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  a_r8_word_cause: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(dec_valid));
  a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_data));
  a_r9_pair_clear: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !have_first);

endmodule

// File: tb/rx_pair_assembler_bench.sv
module rx_pair_assembler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_a_first = 1'b1;
  logic        cfg_low_first = 1'b0;
  logic        ser_valid = 1'b0;
  logic        ser_bit = 1'b0;
  logic        enc_valid;
  logic [9:0]  enc_group;
  logic        dec_valid = 1'b0;
  logic        dec_err = 1'b0;
  logic        dec_ctrl = 1'b0;
  logic [7:0]  dec_byte = '0;
  logic        word_valid;
  logic [19:0] word_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_pair_assembler u_rx_pair_assembler (
    .clk(clk), .rst_n(rst_n), .cfg_a_first(cfg_a_first), .cfg_low_first(cfg_low_first),
    .ser_valid(ser_valid), .ser_bit(ser_bit), .enc_valid(enc_valid), .enc_group(enc_group),
    .dec_valid(dec_valid), .dec_err(dec_err), .dec_ctrl(dec_ctrl), .dec_byte(dec_byte),
    .word_valid(word_valid), .word_data(word_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ser_valid = 1'b0;
    dec_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic pick_bit(input logic [9:0] code, input logic a_first, input int i);
    return a_first ? code[9-i] : code[i];
  endfunction

  task automatic send_code(input logic [9:0] code, input logic a_first, input string req);
    cfg_a_first = a_first;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ser_valid = 1'b1;
      ser_bit = pick_bit(code, a_first, i);
      if (i == 4) begin
        @(negedge clk);
        ser_valid = 1'b0;
        ser_bit = ~ser_bit;
        @(negedge clk);
        chk({req, " no pulse mid-symbol (R4)"}, enc_valid, 1'b0);
        ser_valid = 1'b1;
        ser_bit = pick_bit(code, a_first, i);
        ser_valid = 1'b0;
      end
    end
    @(negedge clk);
    ser_valid = 1'b0;
    chk({req, " enc_valid"}, enc_valid, 1'b1);
    chk({req, " enc_group"}, enc_group, code);
    @(negedge clk);
    chk("R4 enc_valid single cycle", enc_valid, 1'b0);
  endtask

  task automatic send_sym(input logic e, input logic c, input logic [7:0] b);
    @(negedge clk);
    dec_valid = 1'b1;
    dec_err = e;
    dec_ctrl = c;
    dec_byte = b;
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  task automatic pair(input logic low_first, input logic [9:0] s0, input logic [9:0] s1,
                      input string req);
    logic [19:0] exp;
    cfg_low_first = low_first;
    exp = low_first ? {s1, s0} : {s0, s1};
    send_sym(s0[9], s0[8], s0[7:0]);
    chk({req, " no word after one symbol (R8)"}, word_valid, 1'b0);
    send_sym(s1[9], s1[8], s1[7:0]);
    chk({req, " word_valid"}, word_valid, 1'b1);
    chk({req, " word_data"}, word_data, exp);
    @(negedge clk);
    chk("R8 word_valid single cycle", word_valid, 1'b0);
    chk("R8 word_data held", word_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 enc_valid after reset", enc_valid, 1'b0);
    chk("R1 word_valid after reset", word_valid, 1'b0);
    chk("R1 word_data after reset", word_data, 20'h0);
  endtask

  task automatic t_serial();
    send_code(10'b1100000101, 1'b1, "R2 a-first");
    send_code(10'b0011101010, 1'b1, "R2 a-first second");
    send_code(10'b1100000101, 1'b0, "R3 j-first");
    send_code(10'b1000000001, 1'b0, "R3 j-first ends");
  endtask

  task automatic t_words();
    pair(1'b0, {1'b0, 1'b1, 8'hBC}, {1'b0, 1'b0, 8'h5A}, "R6 upper-first R5");
    pair(1'b1, {1'b0, 1'b1, 8'hBC}, {1'b0, 1'b0, 8'h5A}, "R7 lower-first R5");
    pair(1'b0, {1'b0, 1'b0, 8'h80}, {1'b0, 1'b0, 8'h01}, "R5 byte MSB placement");
    pair(1'b0, {1'b1, 1'b0, 8'h00}, {1'b0, 1'b0, 8'h00}, "R9 upper error");
    pair(1'b0, {1'b0, 1'b0, 8'h11}, {1'b0, 1'b0, 8'h22}, "R9 error not carried");
    pair(1'b1, {1'b1, 1'b1, 8'hF7}, {1'b1, 1'b0, 8'h33}, "R9 both errors lower-first");
    pair(1'b1, {1'b0, 1'b0, 8'h44}, {1'b0, 1'b1, 8'h55}, "R9 errors cleared");
  endtask

  task automatic t_reset_mid_pair();
    send_sym(1'b1, 1'b1, 8'hEE);
    do_reset();
    chk("R1 no word after reset", word_valid, 1'b0);
    pair(1'b0, {1'b0, 1'b0, 8'hA1}, {1'b0, 1'b1, 8'hB2}, "R1 pairing restarts");
  endtask

  task automatic t_same_cycle();
    logic [9:0] code;
    code = 10'b0101100110;
    cfg_a_first = 1'b1;
    cfg_low_first = 1'b0;
    send_sym(1'b0, 1'b0, 8'h3C);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ser_valid = 1'b1;
      ser_bit = code[9-i];
      if (i == 9) begin
        dec_valid = 1'b1;
        dec_err = 1'b1;
        dec_ctrl = 1'b0;
        dec_byte = 8'hC3;
      end
    end
    @(negedge clk);
    ser_valid = 1'b0;
    dec_valid = 1'b0;
    chk("R10 enc_valid same cycle", enc_valid, 1'b1);
    chk("R10 enc_group same cycle", enc_group, code);
    chk("R10 word_valid same cycle", word_valid, 1'b1);
    chk("R10 word_data same cycle", word_data, {2'b00, 8'h3C, 2'b10, 8'hC3});
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    t_reset();
    t_serial();
    t_words();
    t_reset_mid_pair();
    t_same_cycle();
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule